// File: doc/BRIEF.md
# Write-Protected I2C Calibration Memory

This block is an I2C target that presents a 16-bit byte-addressed memory to a bus controller. It holds three windows. The first is a read-only identification and factory-calibration area at 0x8000–0x83FF, whose contents are fixed at build time. The second is a 256-byte user-calibration area at 0x7000–0x70FF, held in internal registers. The third is a single unlock register at 0x6FFF, which guards the user area. Software keeps a user calibration record at 0x7000. A valid record starts with the tag byte 0xDD. The factory copy of the record starts at 0x8100.

A controller addresses the target with its 7-bit device address, sends the word address high byte first, and then streams data bytes. To read, it issues a repeated START, sends the device address with the read bit set, and clocks data out. The word address advances by one after every byte, in both directions.

The user area comes out of reset write-protected. Writing 0xD2 to 0x6FFF lifts the protection. Writing any other value there restores it. Writes that are refused are still acknowledged, so the controller sees no bus error.

The bus is open-drain. SCL and SDA arrive as sampled inputs and are synchronised to the block clock. The block pulls SDA low through a single enable output. There is no back-pressure: the target never stretches SCL. The block clock must therefore run at least ten times faster than SCL.

Top module: `cal_i2c_mem`

## Requirements
- R1: After reset the user area is locked, every user byte reads 0xFF, and the SDA pull-down is released.
- R2: Only a header whose upper 7 bits equal DEV_ADDR (default 0x50) is acknowledged. The header's LSB selects the direction (0 = write, 1 = read). After a mismatched header, no byte is acknowledged until the next START.
- R3: A write transfer consists of the header, the address high byte, the address low byte, then data bytes. The target acknowledges each byte by holding SDA low during the 9th SCL pulse. The word address then advances by one after each data byte, wrapping from 0xFFFF to 0x0000.
- R4: A read header makes the target shift out the byte at the word address, MSB first, and advance the address by one. A controller ACK (SDA low on the 9th pulse) continues the read. A controller NACK (SDA high) ends it, and SDA is released before the next SCL high phase.
- R5: Writing 0xD2 to 0x6FFF unlocks the user area. A read of 0x6FFF returns 0x01 while unlocked and 0x00 while locked.
- R6: Writing any value other than 0xD2 to 0x6FFF locks the user area again.
- R7: While the area is locked, writes to 0x7000–0x70FF are acknowledged but change nothing. While it is unlocked, they store the byte.
- R8: The area 0x8000–0x83FF is read-only. Writes to it are acknowledged and ignored. With offset o = address − 0x8000, the byte at offset 0x100 reads 0xDD. Every other byte reads o[7:0] XOR {000000, o[9:8]} XOR 0x5A.
- R9: Addresses outside the three windows, including 0x7100, read 0xFF. Writes to them are acknowledged and ignored.
- R10: A STOP returns the target to idle with SDA released. A repeated START restarts the header phase and keeps the word address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, at least 10x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled level of the SCL wire |
| sda_i | input | 1 | Sampled level of the SDA wire |
| sda_pull_o | output | 1 | 1 = drive SDA low; 0 = release SDA |

## Verification
SCL and SDA each pass through a two-stage synchroniser plus one edge register. Because of that, the target changes its SDA pull about three block clocks after the controller lowers SCL. A stored byte changes one clock after the falling edge of the 8th data bit.

The bench moves SCL and SDA only on 100 ns quarter-bit boundaries. These fall halfway between block clock edges. The bench samples SDA in the middle of the SCL high phase, five clocks after the rise, by which time any target response is long settled.

Each effect on storage or on the lock is checked through a later read transaction on the bus, never at the cycle of the write. Checks that SDA has been released are sampled one quarter-bit after the relevant SCL fall.

// File: rtl/cal_i2c_pkg.sv
`timescale 1ns/1ps
package cal_i2c_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_AHI, ST_AHI_ACK,
    ST_ALO, ST_ALO_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } tgt_state_e;

  localparam logic [15:0] UNLOCK_ADDR_D = 16'h6FFF;
  localparam logic [7:0]  UNLOCK_KEY_D  = 8'hD2;
  localparam logic [15:0] USER_BASE_D   = 16'h7000;
  localparam int          USER_BYTES_D  = 256;
  localparam logic [15:0] RO_BASE_D     = 16'h8000;
  localparam int          RO_BYTES_D    = 1024;
  localparam logic [15:0] TAG_OFF_D     = 16'h0100;
  localparam logic [7:0]  TAG_BYTE_D    = 8'hDD;
  localparam logic [7:0]  RO_SEED_D     = 8'h5A;
endpackage

// File: rtl/cal_bus_sense.sv
`timescale 1ns/1ps
module cal_bus_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop,
  output logic sda_s
);
  logic [1:0] scl_sync, sda_sync;
  logic       scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_d    <= scl_sync[1];
      sda_d    <= sda_sync[1];
    end
  end

  assign sda_s     = sda_sync[1];
  assign scl_rise  = scl_sync[1] & ~scl_d;
  assign scl_fall  = ~scl_sync[1] & scl_d;
  assign bus_start = scl_sync[1] & scl_d & sda_d & ~sda_sync[1];
  assign bus_stop  = scl_sync[1] & scl_d & ~sda_d & sda_sync[1];
endmodule

// File: rtl/cal_byte_engine.sv
`timescale 1ns/1ps
module cal_byte_engine
  import cal_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int         AW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          bus_start,
  input  logic          bus_stop,
  input  logic          sda_s,
  input  logic [7:0]    rd_byte,
  output logic [AW-1:0] ptr,
  output logic [7:0]    wr_byte,
  output logic          wr_en,
  output logic          sda_pull
);
  localparam int ABYTES = AW / 8;

  tgt_state_e st;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       rnw, nack;

  wire rx_state = (st == ST_DEV) || (st == ST_AHI) || (st == ST_ALO) || (st == ST_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; ptr <= '0;
      rnw <= 1'b0; nack <= 1'b0; wr_en <= 1'b0; sda_pull <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (bus_start) begin
        st <= ST_DEV; cnt <= '0; sda_pull <= 1'b0;
      end else if (bus_stop) begin
        st <= ST_IDLE; sda_pull <= 1'b0;
      end else if (scl_rise) begin
        if (rx_state) begin
          sh  <= {sh[6:0], sda_s};
          cnt <= cnt + 4'd1;
        end
        if (st == ST_RD_ACK) nack <= sda_s;
      end else if (scl_fall) begin
        case (st)
          ST_DEV: if (cnt == 4'd8) begin
            if (sh[7:1] == DEV_ADDR) begin
              rnw <= sh[0]; sda_pull <= 1'b1; st <= ST_DEV_ACK;
            end else st <= ST_IDLE;
          end
          ST_AHI: if (cnt == 4'd8) begin
            ptr[AW-1 -: 8] <= sh; sda_pull <= 1'b1; st <= ST_AHI_ACK;
          end
          ST_ALO: if (cnt == 4'd8) begin
            ptr[7:0] <= sh; sda_pull <= 1'b1; st <= ST_ALO_ACK;
          end
          ST_WR: if (cnt == 4'd8) begin
            wr_en <= 1'b1; sda_pull <= 1'b1; st <= ST_WR_ACK;
          end
          ST_DEV_ACK: begin
            cnt <= '0;
            if (rnw) begin
              sh <= rd_byte; sda_pull <= ~rd_byte[7]; st <= ST_RD;
            end else begin
              sda_pull <= 1'b0; st <= (ABYTES > 1) ? ST_AHI : ST_ALO;
            end
          end
          ST_AHI_ACK: begin sda_pull <= 1'b0; cnt <= '0; st <= ST_ALO; end
          ST_ALO_ACK: begin sda_pull <= 1'b0; cnt <= '0; st <= ST_WR; end
          ST_WR_ACK: begin
            sda_pull <= 1'b0; cnt <= '0; ptr <= ptr + 1'b1; st <= ST_WR;
          end
          ST_RD: if (cnt == 4'd7) begin
            sda_pull <= 1'b0; ptr <= ptr + 1'b1; st <= ST_RD_ACK;
          end else begin
            cnt <= cnt + 4'd1; sda_pull <= ~sh[6]; sh <= {sh[6:0], 1'b0};
          end
          ST_RD_ACK: if (!nack) begin
            cnt <= '0; sh <= rd_byte; sda_pull <= ~rd_byte[7]; st <= ST_RD;
          end else st <= ST_IDLE;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign wr_byte = sh;

  p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> (st == ST_IDLE) && !sda_pull);
  p_nack_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RD_ACK) && scl_fall && nack |=> !sda_pull && (st == ST_IDLE));
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WR_ACK) && scl_fall |=> ptr == $past(ptr) + 1'b1);
  p_pull_only_owned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) || (st == ST_DEV) |-> !sda_pull);
endmodule

// File: rtl/cal_store.sv
`timescale 1ns/1ps
module cal_store
  import cal_i2c_pkg::*;
#(
  parameter logic [15:0] UNLOCK_ADDR = UNLOCK_ADDR_D,
  parameter logic [7:0]  UNLOCK_KEY  = UNLOCK_KEY_D,
  parameter logic [15:0] USER_BASE   = USER_BASE_D,
  parameter int          USER_BYTES  = USER_BYTES_D,
  parameter logic [15:0] RO_BASE     = RO_BASE_D,
  parameter int          RO_BYTES    = RO_BYTES_D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  input  logic        wr_en,
  output logic [7:0]  rdata
);
  localparam int UIDX_W = $clog2(USER_BYTES);

  logic [7:0]              ubyte [USER_BYTES];
  logic [USER_BYTES*8-1:0] uflat;
  logic                    unlocked;
  logic [15:0]             uoff, roff;
  logic                    in_user, in_ro, hit_key;
  logic [UIDX_W-1:0]       uidx;

  assign uoff    = addr - USER_BASE;
  assign roff    = addr - RO_BASE;
  assign in_user = uoff < 16'(USER_BYTES);
  assign in_ro   = roff < 16'(RO_BYTES);
  assign uidx    = uoff[UIDX_W-1:0];
  assign hit_key = (addr == UNLOCK_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unlocked <= 1'b0;
    else if (wr_en && hit_key) unlocked <= (wdata == UNLOCK_KEY);
  end

  for (genvar i = 0; i < USER_BYTES; i++) begin : g_user
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ubyte[i] <= 8'hFF;
      else if (wr_en && unlocked && in_user && (uidx == UIDX_W'(i)))
        ubyte[i] <= wdata;
    end
    assign uflat[i*8 +: 8] = ubyte[i];
  end

  function automatic logic [7:0] ro_value(input logic [15:0] o);
    if (o == TAG_OFF_D) return TAG_BYTE_D;
    return o[7:0] ^ {6'b0, o[9:8]} ^ RO_SEED_D;
  endfunction

  always_comb begin
    if (hit_key)      rdata = {7'b0, unlocked};
    else if (in_user) rdata = ubyte[uidx];
    else if (in_ro)   rdata = ro_value(roff);
    else              rdata = 8'hFF;
  end

  p_unlock_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && hit_key && (wdata == UNLOCK_KEY) |=> unlocked);
  p_relock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && hit_key && (wdata != UNLOCK_KEY) |=> !unlocked);
  p_locked_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(uflat));
  p_outside_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && in_user) |=> $stable(uflat));
endmodule

// File: rtl/cal_i2c_mem.sv
`timescale 1ns/1ps
module cal_i2c_mem
  import cal_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o
);
  logic        scl_rise, scl_fall, bus_start, bus_stop, sda_s, wr_en;
  logic [15:0] ptr;
  logic [7:0]  wr_byte, rd_byte;

  cal_bus_sense u_sense (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop), .sda_s(sda_s)
  );

  cal_byte_engine #(.DEV_ADDR(DEV_ADDR), .AW(16)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop), .sda_s(sda_s),
    .rd_byte(rd_byte), .ptr(ptr), .wr_byte(wr_byte), .wr_en(wr_en),
    .sda_pull(sda_pull_o)
  );

  cal_store u_store (
    .clk(clk), .rst_n(rst_n), .addr(ptr), .wdata(wr_byte),
    .wr_en(wr_en), .rdata(rd_byte)
  );
endmodule

// File: tb/test_cal_i2c_mem.sv
`timescale 1ns/1ps
module test_cal_i2c_mem;
  localparam time Q = 100ns;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_pull;
  wire  sda_bus = m_sda & ~sda_pull;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  cal_i2c_mem i_cal_i2c_mem (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_pull_o(sda_pull)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_ro(input logic [15:0] a);
    logic [15:0] o = a - 16'h8000;
    if (o == 16'h0100) return 8'hDD;
    return o[7:0] ^ {6'b0, o[9:8]} ^ 8'h5A;
  endfunction

  task automatic bus_start();
    m_sda = 1'b1; #Q; m_scl = 1'b1; #Q; m_sda = 1'b0; #Q; m_scl = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; #Q; m_scl = 1'b1; #Q; m_sda = 1'b1; #Q;
  endtask

  task automatic wbyte(input logic [7:0] b, output bit nacked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; #Q; m_scl = 1'b1; #(2*Q); m_scl = 1'b0; #Q;
    end
    m_sda = 1'b1; #Q; m_scl = 1'b1; #Q; nacked = sda_bus; #Q; m_scl = 1'b0; #Q;
  endtask

  task automatic rbyte(input bit give_nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #Q; m_scl = 1'b1; #Q; b[i] = sda_bus; #Q; m_scl = 1'b0;
    end
    #Q; m_sda = give_nack; #Q; m_scl = 1'b1; #(2*Q); m_scl = 1'b0; #Q; m_sda = 1'b1;
  endtask

  task automatic put(input logic [15:0] a, input logic [7:0] d0, input logic [7:0] d1,
                     input int n, output bit any_nack);
    logic [7:0] d [2];
    bit k;
    d[0] = d0; d[1] = d1;
    any_nack = 1'b0;
    bus_start();
    wbyte({DEV, 1'b0}, k); any_nack |= k;
    wbyte(a[15:8], k);     any_nack |= k;
    wbyte(a[7:0], k);      any_nack |= k;
    for (int i = 0; i < n; i++) begin wbyte(d[i], k); any_nack |= k; end
    bus_stop();
  endtask

  task automatic get(input logic [15:0] a, input int n, output logic [7:0] q0, output logic [7:0] q1);
    logic [7:0] q [2];
    bit k;
    q[0] = 8'hxx; q[1] = 8'hxx;
    bus_start();
    wbyte({DEV, 1'b0}, k); wbyte(a[15:8], k); wbyte(a[7:0], k);
    bus_start();
    wbyte({DEV, 1'b1}, k);
    for (int i = 0; i < n; i++) rbyte(i == n - 1, q[i]);
    bus_stop();
    q0 = q[0]; q1 = q[1];
  endtask

  task automatic t_reset();
    logic [7:0] a, b;
    chk("R1 sda released", sda_pull, 1'b0);
    get(16'h6FFF, 1, a, b); chk("R1 locked after reset", a, 8'h00);
    get(16'h7000, 2, a, b); chk("R1 user byte 0", a, 8'hFF); chk("R1 user byte 1", b, 8'hFF);
  endtask

  task automatic t_foreign();
    bit k;
    bus_start();
    wbyte({7'h51, 1'b0}, k); chk("R2 foreign header nacked", k, 1'b1);
    wbyte(8'h70, k);         chk("R2 later byte nacked", k, 1'b1);
    bus_stop();
    chk("R10 released after stop", sda_pull, 1'b0);
  endtask

  task automatic t_rom();
    logic [7:0] a, b;
    get(16'h8000, 2, a, b);
    chk("R4/R8 ro 8000", a, exp_ro(16'h8000)); chk("R4/R8 ro 8001", b, exp_ro(16'h8001));
    get(16'h8100, 1, a, b); chk("R8 factory tag", a, 8'hDD);
    get(16'h83FF, 2, a, b);
    chk("R8 ro last", a, exp_ro(16'h83FF)); chk("R9 past ro end", b, 8'hFF);
  endtask

  task automatic t_locked();
    logic [7:0] a, b; bit n;
    put(16'h7000, 8'h11, 8'h00, 1, n); chk("R3 locked write acked", n, 1'b0);
    get(16'h7000, 1, a, b); chk("R7 locked write ignored", a, 8'hFF);
  endtask

  task automatic t_unlock_and_write();
    logic [7:0] a, b; bit n;
    put(16'h6FFF, 8'hD2, 8'h00, 1, n); chk("R3 key write acked", n, 1'b0);
    get(16'h6FFF, 1, a, b); chk("R5 unlocked reads 01", a, 8'h01);
    put(16'h7000, 8'hDD, 8'h22, 2, n); chk("R3 burst acked", n, 1'b0);
    get(16'h7000, 2, a, b);
    chk("R7 stored 7000", a, 8'hDD); chk("R3 increment 7001", b, 8'h22);
  endtask

  task automatic t_ignored_writes();
    logic [7:0] a, b; bit n;
    put(16'h8100, 8'h00, 8'h00, 1, n); chk("R8 ro write acked", n, 1'b0);
    get(16'h8100, 1, a, b); chk("R8 ro unchanged", a, 8'hDD);
    put(16'h1234, 8'h00, 8'h00, 1, n); chk("R9 unmapped write acked", n, 1'b0);
    get(16'h1234, 1, a, b); chk("R9 unmapped reads FF", a, 8'hFF);
    put(16'h70FF, 8'h44, 8'h55, 2, n);
    get(16'h70FF, 2, a, b);
    chk("R7 last user byte", a, 8'h44); chk("R9 7100 not stored", b, 8'hFF);
  endtask

  task automatic t_relock();
    logic [7:0] a, b; bit n;
    put(16'h6FFF, 8'hD3, 8'h00, 1, n);
    get(16'h6FFF, 1, a, b); chk("R6 relocked reads 00", a, 8'h00);
    put(16'h7001, 8'h99, 8'h00, 1, n);
    get(16'h7001, 1, a, b); chk("R6/R7 write after relock ignored", a, 8'h22);
  endtask

  task automatic t_nack_release();
    logic [7:0] a; bit k;
    bus_start();
    wbyte({DEV, 1'b0}, k); wbyte(8'h81, k); wbyte(8'h00, k);
    bus_start();
    wbyte({DEV, 1'b1}, k); chk("R10 repeated start read header acked", k, 1'b0);
    rbyte(1'b1, a);
    chk("R10 pointer kept across restart", a, 8'hDD);
    chk("R4 released after controller nack", sda_pull, 1'b0);
    bus_stop();
  endtask

  initial begin
    #200; rst_n = 1'b1; #(2*Q);
    t_reset();
    t_foreign();
    t_rom();
    t_locked();
    t_unlock_and_write();
    t_ignored_writes();
    t_relock();
    t_nack_release();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule